// File: doc/BRIEF.md
# PID-Indexed Masked Section Filter

This block decides, section by section, whether the header of a table section carried on one of the selected packet identifiers is wanted. The upstream parser tags every header byte with the index of the packet identifier it arrived on (one of 32 substreams) and marks the first byte of each section, which is the table id. The filter compares consecutive header bytes, starting at that first byte, against masked conditions. After the last compared byte it issues one accept or reject result, tagged with the substream index.

The conditions live in one shared pool of 80 four-byte halves. Each half holds a condition word and a mask word. A global width switch selects how the pool is used. In wide mode two neighbouring halves form one 8-byte entry, which gives 40 entries. In narrow mode each half is a 4-byte entry, which gives 80 entries. Every substream owns a contiguous run of entries, set by a base and a count, so one substream can use many conditions and another none. A write port loads the conditions, the masks, the links and the width switch.

Top module: `secfilt_top`

## Requirements
- R1: Each result carries on `resStream` the substream index given with the first byte of the section it concerns. All 32 indices are usable.
- R2: A mask bit of 1 makes the data bit take part in the compare. A mask bit of 0 makes it ignored. Byte k of a half sits in bits [8k+7:8k] of its condition and mask words.
- R3: A section is accepted when at least one entry linked to its substream matches on every compared byte. Otherwise it is rejected.
- R4: In wide mode (mode bit 0 = 1), 8 bytes are compared. Entry j uses half 2j for bytes 0-3 and half 2j+1 for bytes 4-7. Entries 0 to 39 exist.
- R5: In narrow mode (mode bit 0 = 0, the reset value), 4 bytes are compared. Entry j is half j, and entries 0 to 79 exist.
- R6: `resValid` pulses for exactly one cycle, one cycle after the last compared byte (byte 3 or byte 7) is accepted. No pulse follows the earlier bytes.
- R7: A new section start abandons any section still in progress, and that section produces no result.
- R8: A substream with a count of zero accepts every section.
- R9: Write port encoding. `wrSel` 0 writes the condition of half `wrIdx`, 1 writes its mask, and 2 writes the link of substream `wrIdx` (base in bits [7:0], count in bits [15:8]). `wrSel` 3 writes the mode bit from bit 0.
- R10: Entries outside a substream's linked range never cause an accept for that substream, even when their condition matches.
- R11: After reset no result is pending, all links are zero and the mode is narrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 2 | Write target: condition, mask, link, mode |
| wrIdx | input | 8 | Half index or substream index |
| wrData | input | 32 | Write data |
| inValid | input | 1 | Header byte present |
| inStart | input | 1 | Byte is the first of a section (table id) |
| inPid | input | 5 | Substream index of the byte |
| inByte | input | 8 | Header byte |
| resValid | output | 1 | Result pulse |
| resAccept | output | 1 | 1 = section accepted |
| resStream | output | 5 | Substream index of the result |

## Verification
The bench uses the default sizes: 32 substreams and an 80-half pool. This makes the last half (79) and the last wide entry (39) reachable, along with runs that extend past the end of the pool. Random sections are run in both modes. About half of them are built from a linked condition, with noise placed only under zero mask bits. The rest are random bytes, so both accept and reject outcomes occur often. Directed cases cover zero-count links, masked-off bits, unlinked but matching entries, and a section cut short by a new start.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;
  typedef struct packed {
    logic first;   // section start byte, compare at position 0
    logic adv;     // later byte of the open section
  } strobe_t;

  localparam logic [1:0] SEL_COND = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_LINK = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;
endpackage

// File: rtl/secfilt_dp.sv
module secfilt_dp
  import secfilt_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int NUM_HALVES  = 80,
  localparam int SW = $clog2(NUM_STREAMS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [7:0]    wrIdx,
  input  logic [31:0]   wrData,
  input  strobe_t       stb,
  input  logic [2:0]    pos,
  input  logic [SW-1:0] pidSel,
  input  logic [7:0]    inByte,
  output logic          wideMode,
  output logic          hitNow
);
  localparam int NPAIR = NUM_HALVES / 2;

  logic [31:0] cond [NUM_HALVES];
  logic [31:0] mask [NUM_HALVES];
  logic [7:0]  linkBase [NUM_STREAMS];
  logic [7:0]  linkCnt  [NUM_STREAMS];
  logic [NUM_HALVES-1:0] alive, nxt;
  logic [NPAIR-1:0] pairHit;
  logic [7:0] base, cnt;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideMode <= 1'b0;
      for (int s = 0; s < NUM_STREAMS; s++) begin
        linkBase[s] <= '0;
        linkCnt[s]  <= '0;
      end
      for (int h = 0; h < NUM_HALVES; h++) begin
        cond[h] <= '0;
        mask[h] <= '0;
      end
    end else if (wrEn) begin
      case (wrSel)
        SEL_COND: if (int'(wrIdx) < NUM_HALVES) cond[wrIdx] <= wrData;
        SEL_MASK: if (int'(wrIdx) < NUM_HALVES) mask[wrIdx] <= wrData;
        SEL_LINK: if (int'(wrIdx) < NUM_STREAMS) begin
          linkBase[wrIdx[SW-1:0]] <= wrData[7:0];
          linkCnt[wrIdx[SW-1:0]]  <= wrData[15:8];
        end
        default: wideMode <= wrData[0];
      endcase
    end
  end

  assign base = linkBase[pidSel];
  assign cnt  = linkCnt[pidSel];

  // one masked byte comparator per pool half
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [8:0] entry;
    logic inRange, covers, eq;
    logic [7:0] condByte, maskByte;
    assign entry    = wideMode ? 9'(h / 2) : 9'(h);
    assign inRange  = (entry >= {1'b0, base}) && (entry < ({1'b0, base} + {1'b0, cnt}));
    assign covers   = wideMode ? (pos[2] == 1'(h % 2)) : 1'b1;
    assign condByte = cond[h][{pos[1:0], 3'b000} +: 8];
    assign maskByte = mask[h][{pos[1:0], 3'b000} +: 8];
    assign eq       = ((inByte ^ condByte) & maskByte) == 8'd0;
    assign nxt[h]   = (stb.first ? inRange : alive[h]) & (~covers | eq);
  end

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    assign pairHit[j] = nxt[2*j] & nxt[2*j+1];
  end

  assign hitNow = (cnt == 8'd0) | (wideMode ? |pairHit : |nxt);

  always_ff @(posedge clk) begin
    if (!rstN) alive <= '0;
    else if (stb.first || stb.adv) alive <= nxt;
  end

  // R7: compare state only moves on section bytes
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.first || stb.adv) |=> $stable(alive));
  // R11: reset leaves no live compare
  a_r11_reset_clear: assert property (@(posedge clk)
    !rstN |=> alive == '0);
endmodule

// File: rtl/secfilt_ctl.sv
module secfilt_ctl
  import secfilt_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  localparam int SW = $clog2(NUM_STREAMS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inStart,
  input  logic [SW-1:0] inPid,
  input  logic          wideMode,
  input  logic          hitNow,
  output strobe_t       stb,
  output logic [2:0]    pos,
  output logic [SW-1:0] pidSel,
  output logic          resValid,
  output logic          resAccept,
  output logic [SW-1:0] resStream
);
  logic          active;
  logic [2:0]    curPos;
  logic [SW-1:0] curPid;
  logic [2:0]    lastPos;

  assign lastPos   = wideMode ? 3'd7 : 3'd3;
  assign stb.first = inValid & inStart;
  assign stb.adv   = inValid & ~inStart & active;
  assign pos       = stb.first ? 3'd0 : curPos;
  assign pidSel    = stb.first ? inPid : curPid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      curPos    <= '0;
      curPid    <= '0;
      resValid  <= 1'b0;
      resAccept <= 1'b0;
      resStream <= '0;
    end else begin
      resValid <= 1'b0;
      if (stb.first) begin
        active <= 1'b1;
        curPos <= 3'd1;
        curPid <= inPid;
      end else if (stb.adv) begin
        if (curPos == lastPos) begin
          active    <= 1'b0;
          resValid  <= 1'b1;
          resAccept <= hitNow;
          resStream <= curPid;
        end else begin
          curPos <= curPos + 3'd1;
        end
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  a_r6_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid && !inStart));
  a_r7_start_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart) |=> !resValid);
  a_r1_stream_held: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resStream == $past(curPid));
endmodule

// File: rtl/secfilt_top.sv
module secfilt_top
  import secfilt_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int NUM_HALVES  = 80,
  localparam int SW = $clog2(NUM_STREAMS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [7:0]    wrIdx,
  input  logic [31:0]   wrData,
  input  logic          inValid,
  input  logic          inStart,
  input  logic [SW-1:0] inPid,
  input  logic [7:0]    inByte,
  output logic          resValid,
  output logic          resAccept,
  output logic [SW-1:0] resStream
);
  strobe_t       stb;
  logic [2:0]    pos;
  logic [SW-1:0] pidSel;
  logic          wideMode, hitNow;

  secfilt_ctl #(.NUM_STREAMS(NUM_STREAMS)) i_ctl (
    .clk, .rstN, .inValid, .inStart, .inPid, .wideMode, .hitNow,
    .stb, .pos, .pidSel, .resValid, .resAccept, .resStream
  );

  secfilt_dp #(.NUM_STREAMS(NUM_STREAMS), .NUM_HALVES(NUM_HALVES)) i_dp (
    .clk, .rstN, .wrEn, .wrSel, .wrIdx, .wrData, .stb, .pos, .pidSel,
    .inByte, .wideMode, .hitNow
  );
endmodule

// File: tb/test_secfilt_top.sv
module test_secfilt_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrIdx = '0;
  logic [31:0] wrData = '0;
  logic inValid = 1'b0, inStart = 1'b0;
  logic [4:0] inPid = '0;
  logic [7:0] inByte = '0;
  logic resValid, resAccept;
  logic [4:0] resStream;

  int errors = 0;
  int checks = 0;

  bit [31:0] mCond [80];
  bit [31:0] mMask [80];
  int mBase [32];
  int mCnt [32];
  bit mWide = 0;

  always #5 clk = ~clk;

  secfilt_top i_secfilt_top (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = 8'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (sel)
      2'd0: mCond[idx] = d;
      2'd1: mMask[idx] = d;
      2'd2: begin mBase[idx] = int'(d[7:0]); mCnt[idx] = int'(d[15:8]); end
      default: mWide = d[0];
    endcase
  endtask

  function automatic bit modelHit(input int pid, input logic [63:0] b);
    int len = mWide ? 8 : 4;
    int lim = mWide ? 40 : 80;
    if (mCnt[pid] == 0) return 1'b1;
    for (int e = mBase[pid]; e < mBase[pid] + mCnt[pid]; e++) begin
      bit ok = 1'b1;
      if (e >= lim) continue;
      for (int k = 0; k < len; k++) begin
        int hf = mWide ? 2*e + k/4 : e;
        bit [7:0] cb = 8'(mCond[hf] >> ((k%4)*8));
        bit [7:0] mb = 8'(mMask[hf] >> ((k%4)*8));
        if (((b[8*k +: 8] ^ cb) & mb) != 8'd0) ok = 1'b0;
      end
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  // drives len bytes back to back, then samples the result one cycle later
  task automatic sendSection(input int pid, input logic [63:0] b, input int len,
                             output bit gotV, output bit gotA, output int gotS, output bit early);
    early = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k > 0 && resValid) early = 1'b1;
      inValid = 1'b1; inStart = (k == 0); inPid = 5'(pid); inByte = b[8*k +: 8];
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0;
    gotV = resValid; gotA = resAccept; gotS = int'(resStream);
  endtask

  task automatic runCheck(input int pid, input logic [63:0] b, input string tag);
    bit v, a, e; int s;
    bit exp = modelHit(pid, b);
    sendSection(pid, b, mWide ? 8 : 4, v, a, s, e);
    check(v && !e, {tag, " R6 pulse timing"}, int'(v), 1);
    check(a == exp, {tag, " R3 accept"}, int'(a), int'(exp));
    check(s == pid, {tag, " R1 stream"}, s, pid);
  endtask

  function automatic logic [63:0] buildBytes(input int pid);
    logic [63:0] b = {$urandom, $urandom};
    int lim = mWide ? 40 : 80;
    if (mCnt[pid] > 0 && ($urandom % 2) == 1) begin
      int e = mBase[pid] + int'($urandom % mCnt[pid]);
      if (e < lim)
        for (int k = 0; k < 8; k++) begin
          int hf = mWide ? 2*e + (k/4)%2 : e;
          bit [7:0] cb = 8'(mCond[hf] >> ((k%4)*8));
          bit [7:0] mb = 8'(mMask[hf] >> ((k%4)*8));
          b[8*k +: 8] = cb ^ (8'($urandom) & ~mb);
        end
    end
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit v, a, e; int s;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin mBase[i] = 0; mCnt[i] = 0; end
    for (int i = 0; i < 80; i++) begin mCond[i] = 0; mMask[i] = 0; end
    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R11 reset no result", int'(resValid), 0);
    rstN = 1'b1;

    // R11/R8: after reset every link count is zero, so anything is accepted
    sendSection(9, 64'h0123_4567_89ab_cdef, 4, v, a, s, e);
    check(v && a && s == 9, "R11 R8 reset links zero", int'(a), 1);

    // R2 R9: narrow, half 5 masked compare
    wr(2'd0, 5, 32'h4433_2211);
    wr(2'd1, 5, 32'hFF00_FF00);
    wr(2'd2, 3, 32'h0000_0105);
    runCheck(3, 64'h44_5C_22_AB, "R2 masked-off bits ignored");
    check(resAccept == 1'b1, "R2 accept masked", int'(resAccept), 1);
    runCheck(3, 64'h44_5C_23_AB, "R2 cared bit differs");
    check(resAccept == 1'b0, "R2 reject", int'(resAccept), 0);

    // R10: half 6 matches but is not linked to stream 3
    wr(2'd0, 6, 32'hDEAD_BEEF);
    wr(2'd1, 6, 32'hFFFF_FFFF);
    runCheck(3, 64'hDE_AD_BE_EF, "R10 unlinked entry");
    check(resAccept == 1'b0, "R10 unlinked reject", int'(resAccept), 0);

    // R8: zero count
    wr(2'd2, 7, 32'h0000_0000);
    runCheck(7, 64'h1234_5678, "R8 zero count");
    check(resAccept == 1'b1, "R8 accept", int'(resAccept), 1);

    // R5: last narrow half
    wr(2'd0, 79, 32'hA1B2_C3D4);
    wr(2'd1, 79, 32'hFFFF_FFFF);
    wr(2'd2, 30, 32'h0000_014F);
    runCheck(30, 64'hA1_B2_C3_D4, "R5 half 79");
    check(resAccept == 1'b1, "R5 accept", int'(resAccept), 1);

    // R7: abandoned section, then a full one on stream 7
    @(negedge clk); inValid = 1; inStart = 1; inPid = 5'd3; inByte = 8'hAB;
    @(negedge clk); inStart = 0; inByte = 8'h22;
    @(negedge clk); inStart = 1; inPid = 5'd7; inByte = 8'h00;
    check(resValid == 1'b0, "R7 no result on abort", int'(resValid), 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); inStart = 0; inByte = 8'(k);
      check(resValid == 1'b0, "R7 no early result", int'(resValid), 0);
    end
    @(negedge clk); inValid = 0;
    check(resValid && resStream == 5'd7, "R7 only new section reports", int'(resStream), 7);

    // R4: wide entry 39 = halves 78 and 79
    wr(2'd3, 0, 32'h1);
    wr(2'd0, 78, 32'h0403_0201);
    wr(2'd1, 78, 32'hFFFF_FFFF);
    wr(2'd2, 31, 32'h0000_0127);
    runCheck(31, 64'hA1B2C3D4_04030201, "R4 entry 39 match");
    check(resAccept == 1'b1, "R4 accept", int'(resAccept), 1);
    runCheck(31, 64'hA1B3C3D4_04030201, "R4 upper half byte 6");
    check(resAccept == 1'b0, "R4 reject", int'(resAccept), 0);

    // random in both modes
    for (int m = 0; m < 2; m++) begin
      wr(2'd3, 0, 32'(m));
      for (int h = 0; h < 80; h++) begin
        wr(2'd0, h, $urandom);
        wr(2'd1, h, $urandom & $urandom);
      end
      for (int r = 0; r < 300; r++) begin
        if (r % 50 == 0)
          for (int p = 0; p < 32; p++)
            wr(2'd2, p, {16'd0, 8'($urandom % 4), 8'($urandom % 82)});
        begin
          int p = int'($urandom % 32);
          runCheck(p, buildBytes(p), m ? "R4 random wide" : "R5 random narrow");
        end
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule